// File: doc/BRIEF.md
# Trap Guard with Sticky Event Flags

This block protects a nine-channel output stage against an external fault. A selector chooses one of sixteen fault lines. That line passes through a two-stage synchronizer, and an edge detector watches it for a rising or a falling edge, as configured. A detected edge sets two things: a sticky trap flag that software can acknowledge, and a trap state. While the trap state holds, every channel marked as trap-protected drives its passive level in place of its normal value. The passive level comes from that channel's polarity bit.

Software controls the flag and the state separately. It can set the trap flag without entering the trap state, for example to test the interrupt path. It can also force a full trap. Releasing the state gives the channels back their normal outputs and leaves the flag as it was. Two strobes from the channel FIFOs set two more sticky flags, one for full and one for empty. Each of the three flags has its own interrupt enable, and all enabled flags share a single interrupt line. In this block the register writes are plain one-cycle strobes.

Top module: `trap_event_guard`

## Requirements
- R1: Only the line chosen by `trap_sel` can start a trap. Edges on any other line leave the trap state and the flags unchanged.
- R2: When `trap_edge_fall` is 0, a 0-to-1 change on the selected line sets `trap_state` and `evt_flags[0]`. Both are visible after the third rising clock edge following the change, and not after the second.
- R3: When `trap_edge_fall` is 1, a 1-to-0 change on the selected line traps with the same three-edge latency, and a 0-to-1 change does not trap.
- R4: While `trap_state` is 1, each channel with `ch_trap_en[i]`=1 outputs `ch_pol[i]` (1 means active low, so the passive level is high; 0 means active high, so the passive level is low). Channels with `ch_trap_en[i]`=0 pass `ch_raw[i]`.
- R5: While `trap_state` is 0, `ch_out` equals `ch_raw` on every channel.
- R6: A pulse on `evt_set[0]` sets the trap flag (`evt_flags[0]`) on the next edge and leaves `trap_state` at 0.
- R7: A pulse on `trap_force` sets both `trap_state` and `evt_flags[0]` on the next edge.
- R8: A pulse on `trap_release` clears `trap_state` on the next edge and leaves the trap flag unchanged. A pulse on `evt_clr[0]` clears only the trap flag and leaves `trap_state` unchanged.
- R9: `fifo_full_evt` sets `evt_flags[1]` and `fifo_empty_evt` sets `evt_flags[2]`. Every flag stays set until its `evt_clr` bit is pulsed. The flag positions are bit 0 for trap, bit 1 for full and bit 2 for empty, in `evt_set`, `evt_clr`, `irq_en` and `evt_flags`.
- R10: When a set source and a clear for the same flag or state arrive in the same cycle, the flag or state ends up 1.
- R11: `irq` is 1 exactly when some bit of `evt_flags` and the same bit of `irq_en` are both 1.
- R12: `trap_level` shows the present raw level of the selected line with no clock delay.
- R13: After reset, `evt_flags` is 0 and `trap_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_in | input | 16 | Fault lines, asynchronous |
| trap_sel | input | 4 | Index of the watched fault line |
| trap_edge_fall | input | 1 | 0: trap on rising edge, 1: trap on falling edge |
| ch_trap_en | input | 9 | Per-channel trap protection enable |
| ch_pol | input | 9 | Per-channel polarity, 1 = active low (passive high) |
| ch_raw | input | 9 | Channel outputs before gating |
| fifo_full_evt | input | 1 | Strobe: write attempted to a full FIFO |
| fifo_empty_evt | input | 1 | Strobe: read attempted from an empty FIFO |
| evt_set | input | 3 | Write-one-to-set strobes for the flags |
| evt_clr | input | 3 | Write-one-to-clear strobes for the flags |
| trap_force | input | 1 | Software trap entry (sets state and flag) |
| trap_release | input | 1 | Software trap exit (clears state) |
| irq_en | input | 3 | Per-flag interrupt enables |
| ch_out | output | 9 | Gated channel outputs |
| evt_flags | output | 3 | Sticky flags {empty, full, trap} |
| trap_state | output | 1 | Trap state active |
| trap_level | output | 1 | Raw level of the selected fault line |
| irq | output | 1 | Combined interrupt |

## Verification
The bench measures trap latency exactly. It checks that the state is still clear after the second edge and set after the third, so an extra or a missing synchronizer stage fails. It drives each edge direction in the wrong mode and puts edges on an unselected line, which exposes a detector that ignores the mode bit or the selector. It applies set and clear in the same cycle, both from software and from the hardware strobes; a design where clear wins would lose those events. It also separates the flag from the state: a design that let a flag-set enter the trap state, or let a release clear the flag, would gate the channels when it should not, or drop the acknowledgment software relies on.

// File: rtl/trap_guard_pkg.sv
// Shared constants for the trap guard: flag indices and default sizes.
// Assumes every flag vector in the block uses these bit positions.
package trap_guard_pkg;
    localparam int EV_TRAP   = 0;
    localparam int EV_FULL   = 1;
    localparam int EV_EMPTY  = 2;
    localparam int NUM_EV    = 3;
    localparam int DEF_CH    = 9;
    localparam int DEF_LINES = 16;
endpackage

// File: rtl/trap_edge_detect.sv
// Selects one fault line, synchronizes it through two flops and flags the
// configured edge. Assumes the selector and the edge mode change only while
// the lines are quiet; a change made while a line is active can look like an edge.
module trap_edge_detect #(
    parameter int LINES = 16,
    localparam int SEL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             fall_i,
    output logic             fire_o,
    output logic             level_o
);
    logic sync1, sync2, prev;

    // Raw level of the watched line, shown without any clock delay.
    assign level_o = lines_i[sel_i];

    // Synchronizer chain plus a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= level_o;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Edge decode for the selected direction.
    always_comb begin
        if (fall_i) fire_o = prev & ~sync2;
        else        fire_o = sync2 & ~prev;
    end

    // An edge lasts one cycle, because the history flop catches up.
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && $stable(fall_i)) |=> !fire_o);
endmodule

// File: rtl/sticky_flag_bank.sv
// A bank of sticky flags with set priority over clear, and an OR of the
// enabled flags. Assumes the set and clear inputs are one-cycle strobes.
module sticky_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    // One flop per flag; a set overrides a clear in the same cycle.
    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[k] <= 1'b0;
            else if (set_i[k]) flag_o[k] <= 1'b1;
            else if (clr_i[k]) flag_o[k] <= 1'b0;
        end

        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flag_o[k]);
        assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flag_o[k]);
        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[k] && !clr_i[k]) |=> flag_o[k]);
    end

    // Combined interrupt from the enabled flags.
    assign irq_o = |(flag_o & en_i);
endmodule

// File: rtl/channel_trap_gate.sv
// Replaces each trap-protected channel with its passive level while the
// trap state is active. Assumes polarity 1 = active low (passive high).
module channel_trap_gate #(
    parameter int CH = 9
) (
    input  logic          trap_i,
    input  logic [CH-1:0] en_i,
    input  logic [CH-1:0] pol_i,
    input  logic [CH-1:0] raw_i,
    output logic [CH-1:0] out_o
);
    // Per-channel output multiplexer.
    for (genvar i = 0; i < CH; i++) begin : g_ch
        assign out_o[i] = (trap_i && en_i[i]) ? pol_i[i] : raw_i[i];
    end
endmodule

// File: rtl/trap_event_guard.sv
// Top level: fault-line watch, trap state, sticky event flags, interrupt
// and channel gating. Assumes register writes arrive as one-cycle strobes.
module trap_event_guard
    import trap_guard_pkg::*;
#(
    parameter int NUM_CH    = DEF_CH,
    parameter int NUM_LINES = DEF_LINES,
    localparam int SEL_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LINES-1:0] trap_in,
    input  logic [SEL_W-1:0]  trap_sel,
    input  logic              trap_edge_fall,
    input  logic [NUM_CH-1:0] ch_trap_en,
    input  logic [NUM_CH-1:0] ch_pol,
    input  logic [NUM_CH-1:0] ch_raw,
    input  logic              fifo_full_evt,
    input  logic              fifo_empty_evt,
    input  logic [NUM_EV-1:0] evt_set,
    input  logic [NUM_EV-1:0] evt_clr,
    input  logic              trap_force,
    input  logic              trap_release,
    input  logic [NUM_EV-1:0] irq_en,
    output logic [NUM_CH-1:0] ch_out,
    output logic [NUM_EV-1:0] evt_flags,
    output logic              trap_state,
    output logic              trap_level,
    output logic              irq
);
    logic              trap_fire;
    logic [NUM_EV-1:0] flag_set;

    trap_edge_detect #(.LINES(NUM_LINES)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (trap_in),
        .sel_i   (trap_sel),
        .fall_i  (trap_edge_fall),
        .fire_o  (trap_fire),
        .level_o (trap_level)
    );

    // Gather the set sources for each flag.
    always_comb begin
        flag_set           = evt_set;
        flag_set[EV_TRAP]  = evt_set[EV_TRAP] | trap_fire | trap_force;
        flag_set[EV_FULL]  = evt_set[EV_FULL] | fifo_full_evt;
        flag_set[EV_EMPTY] = evt_set[EV_EMPTY] | fifo_empty_evt;
    end

    sticky_flag_bank #(.N(NUM_EV)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (evt_clr),
        .en_i   (irq_en),
        .flag_o (evt_flags),
        .irq_o  (irq)
    );

    // Trap state: entered by a detected edge or a forced trap, left by release.
    always_ff @(posedge clk) begin
        if (!rst_n)                       trap_state <= 1'b0;
        else if (trap_fire || trap_force) trap_state <= 1'b1;
        else if (trap_release)            trap_state <= 1'b0;
    end

    channel_trap_gate #(.CH(NUM_CH)) u_gate (
        .trap_i (trap_state),
        .en_i   (ch_trap_en),
        .pol_i  (ch_pol),
        .raw_i  (ch_raw),
        .out_o  (ch_out)
    );

    assert_state_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_state) |-> $past(trap_fire || trap_force));
    assert_fire_sets_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire |=> (trap_state && evt_flags[EV_TRAP]));
    assert_force_sets_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_force |=> (trap_state && evt_flags[EV_TRAP]));
    assert_idle_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_state |-> (ch_out == ch_raw));
endmodule

// File: tb/trap_event_guard_bench.sv
`timescale 1ns/1ps
module trap_event_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] trap_in = '0;
    logic [3:0]  trap_sel = '0;
    logic        trap_edge_fall = 1'b0;
    logic [8:0]  ch_trap_en = '0, ch_pol = '0, ch_raw = '0;
    logic        fifo_full_evt = 1'b0, fifo_empty_evt = 1'b0;
    logic [2:0]  evt_set = '0, evt_clr = '0, irq_en = '0;
    logic        trap_force = 1'b0, trap_release = 1'b0;
    logic [8:0]  ch_out;
    logic [2:0]  evt_flags;
    logic        trap_state, trap_level, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    trap_event_guard u_trap_event_guard (
        .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .trap_sel(trap_sel),
        .trap_edge_fall(trap_edge_fall), .ch_trap_en(ch_trap_en), .ch_pol(ch_pol),
        .ch_raw(ch_raw), .fifo_full_evt(fifo_full_evt), .fifo_empty_evt(fifo_empty_evt),
        .evt_set(evt_set), .evt_clr(evt_clr), .trap_force(trap_force),
        .trap_release(trap_release), .irq_en(irq_en), .ch_out(ch_out),
        .evt_flags(evt_flags), .trap_state(trap_state), .trap_level(trap_level), .irq(irq)
    );

    // Rows: {set[2:0], clr[2:0], full, empty, en[2:0], exp_flags[2:0], exp_irq}
    localparam int ROWS = 9;
    localparam logic [14:0] VEC [ROWS] = '{
        {3'b001, 3'b000, 1'b0, 1'b0, 3'b000, 3'b001, 1'b0},
        {3'b000, 3'b000, 1'b0, 1'b0, 3'b001, 3'b001, 1'b1},
        {3'b000, 3'b000, 1'b1, 1'b0, 3'b001, 3'b011, 1'b1},
        {3'b000, 3'b001, 1'b0, 1'b0, 3'b010, 3'b010, 1'b1},
        {3'b000, 3'b010, 1'b0, 1'b0, 3'b010, 3'b000, 1'b0},
        {3'b000, 3'b000, 1'b0, 1'b1, 3'b100, 3'b100, 1'b1},
        {3'b010, 3'b010, 1'b0, 1'b0, 3'b000, 3'b110, 1'b0},
        {3'b000, 3'b010, 1'b1, 1'b0, 3'b010, 3'b110, 1'b1},
        {3'b000, 3'b110, 1'b0, 1'b0, 3'b111, 3'b000, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic [8:0] gated(input logic [8:0] raw);
        return (raw & ~ch_trap_en) | (ch_pol & ch_trap_en);
    endfunction

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        ch_trap_en = 9'b1_0010_0101;
        ch_pol     = 9'b0_1100_0001;
        ch_raw     = 9'b1_0101_1010;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R13 reset state
        chk("R13 flags after reset", 32'(evt_flags), 32'h0);
        chk("R13 state after reset", 32'(trap_state), 32'h0);
        chk("R5 passthrough after reset", 32'(ch_out), 32'(ch_raw));

        // R1 / R12: edge on an unselected line
        trap_sel = 4'd5;
        trap_in[3] = 1'b1;
        #1 chk("R12 level of selected line", 32'(trap_level), 32'h0);
        tick(5);
        chk("R1 unselected line no trap", 32'(trap_state), 32'h0);
        chk("R1 unselected line no flag", 32'(evt_flags), 32'h0);
        trap_in[3] = 1'b0;
        tick(4);

        // R2: rising edge with exact latency
        trap_sel = 4'd3;
        tick(4);
        trap_in[3] = 1'b1;
        #1 chk("R12 level follows line", 32'(trap_level), 32'h1);
        tick(2);
        chk("R2 no trap after two edges", 32'(trap_state), 32'h0);
        tick(1);
        chk("R2 state after third edge", 32'(trap_state), 32'h1);
        chk("R2 flag after third edge", 32'(evt_flags[0]), 32'h1);
        chk("R4 gated outputs", 32'(ch_out), 32'(gated(ch_raw)));
        ch_raw = 9'b0_1010_0101;
        #1 chk("R4 gated outputs second pattern", 32'(ch_out), 32'(gated(ch_raw)));

        // R8: release keeps flag
        tick(1);
        trap_release = 1'b1;
        tick(1);
        trap_release = 1'b0;
        chk("R8 release clears state", 32'(trap_state), 32'h0);
        chk("R8 release keeps flag", 32'(evt_flags[0]), 32'h1);
        chk("R5 outputs restored", 32'(ch_out), 32'(ch_raw));
        trap_in[3] = 1'b0;
        tick(5);
        chk("R3 falling edge ignored in rising mode", 32'(trap_state), 32'h0);

        // R8: flag clear leaves state alone (state is 0 here, then force with it set)
        evt_clr = 3'b001;
        tick(1);
        evt_clr = 3'b000;
        chk("R8 flag clear", 32'(evt_flags[0]), 32'h0);

        // R3: falling mode
        trap_edge_fall = 1'b1;
        tick(3);
        trap_in[3] = 1'b1;
        tick(5);
        chk("R3 rising edge ignored in falling mode", 32'(trap_state), 32'h0);
        trap_in[3] = 1'b0;
        tick(2);
        chk("R3 no trap after two edges", 32'(trap_state), 32'h0);
        tick(1);
        chk("R3 falling edge traps", 32'(trap_state), 32'h1);
        evt_clr = 3'b001;
        tick(1);
        evt_clr = 3'b000;
        chk("R8 flag clear keeps state", 32'(trap_state), 32'h1);
        trap_release = 1'b1;
        tick(1);
        trap_release = 1'b0;
        chk("R8 release after falling trap", 32'(trap_state), 32'h0);

        // R7: software forced trap
        trap_force = 1'b1;
        tick(1);
        trap_force = 1'b0;
        chk("R7 force sets state", 32'(trap_state), 32'h1);
        chk("R7 force sets flag", 32'(evt_flags[0]), 32'h1);
        chk("R4 gated under forced trap", 32'(ch_out), 32'(gated(ch_raw)));
        // R10: force and release together
        trap_force = 1'b1;
        trap_release = 1'b1;
        tick(1);
        trap_force = 1'b0;
        trap_release = 1'b0;
        chk("R10 force beats release", 32'(trap_state), 32'h1);
        trap_release = 1'b1;
        evt_clr = 3'b001;
        tick(1);
        trap_release = 1'b0;
        evt_clr = 3'b000;
        chk("R8 state cleared", 32'(trap_state), 32'h0);

        // R6: flag-set does not trap
        evt_set = 3'b001;
        tick(1);
        evt_set = 3'b000;
        chk("R6 flag set", 32'(evt_flags[0]), 32'h1);
        chk("R6 no trap state", 32'(trap_state), 32'h0);
        chk("R6 outputs not gated", 32'(ch_out), 32'(ch_raw));
        evt_clr = 3'b001;
        tick(1);
        evt_clr = 3'b000;

        // Flag and interrupt table: R9 R10 R11
        for (int r = 0; r < ROWS; r++) begin
            evt_set        = VEC[r][14:12];
            evt_clr        = VEC[r][11:9];
            fifo_full_evt  = VEC[r][8];
            fifo_empty_evt = VEC[r][7];
            irq_en         = VEC[r][6:4];
            tick(1);
            evt_set = '0;
            evt_clr = '0;
            fifo_full_evt = 1'b0;
            fifo_empty_evt = 1'b0;
            chk($sformatf("R9/R10 flags row %0d", r), 32'(evt_flags), 32'(VEC[r][3:1]));
            chk($sformatf("R11 irq row %0d", r), 32'(irq), 32'(VEC[r][0]));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule